// File: doc/BRIEF.md
# Emergency and Status Flag Register

This block keeps the flag bank and the status register of a motion controller, and latches the two active-low emergency inputs: an end-of-travel limit and a stop request. The host changes one flag per write by sending an indexed command word, where one bit carries the new value and three bits select the flag. The profile generator marks the start and the end of a trapezoid move through two event inputs, and these drive flag bit 0.

Each emergency pin passes through a reset-to-high synchronizer before it is latched. A latched limit forces the motor command to zero. A latched stop requests a decelerated stop to zero velocity. Either latch is released only by a write to the status register that arrives while the synchronized pin is already high. The same write also updates the four configuration bits of the status register, whether or not the pin is still low. A soft-reset write of 00h to address 05h clears those configuration bits. It leaves every flag alone.

Top module: `emerg_flag_regs`

## Requirements
- R1: A write to address 00h changes only the flag chosen by data bits 2..0, setting it to data bit 3. Data bits 7..4 and all other flags are unaffected.
- R2: Flag bit 1 is protected from the host. Writes that select index 1 leave it unchanged, and it stays 0.
- R3: `prof_start` sets flag bit 0 and `prof_done` clears it. If both arrive in the same cycle, `prof_done` wins. Either event overrides a host write to index 0 in that cycle.
- R4: An emergency pin held low sets its flag on the third rising edge at which it is sampled low (two synchronizer stages and then the latch). The flag stays set while the pin is low.
- R5: A pin returning high does not clear its flag by itself. The flag clears at a write to address 07h made while the synchronized pin is high.
- R6: A write to 07h while a pin is still low leaves that flag set. It still loads data bits 3..0 into the configuration field.
- R7: Reading 07h returns {0, stop flag, profile flag, limit flag, config[3:0]} from bit 7 down to bit 0. Bits 7..4 ignore write data.
- R8: `cmd_zero` equals the limit flag and `decel_req` equals the stop flag, cycle for cycle.
- R9: Writing 00h to 05h clears the configuration field and pulses `soft_rst_o` for one cycle. It does not change any flag. A non-zero write to 05h has no effect.
- R10: After reset all flags, the configuration and every output are 0. Reads of addresses other than 00h and 07h return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (combinational) |
| limit_n | input | 1 | Active-low limit emergency pin |
| stop_n | input | 1 | Active-low stop emergency pin |
| prof_start | input | 1 | Profile generator: move started |
| prof_done | input | 1 | Profile generator: command profile finished |
| flags_o | output | 8 | Flag bank contents |
| cmd_zero | output | 1 | Force motor command to zero |
| decel_req | output | 1 | Decelerated-stop request |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The hardest case to reach is the release condition. It needs a pin to go low, then return high, then get through the synchronizer, and only then meet a status write. A write placed even one cycle too early must still leave the flag set. Directed sequences write to 07h while a pin is low, then again inside the synchronizer delay after the pin rises, and finally once the high level is through. A random phase then drives pin pulses, mixed writes and profile events against a queue-based reference model that is compared on every clock.

// File: rtl/emflag_pkg.sv
package emflag_pkg;

  localparam int FLAG_N   = 8;
  localparam int EM_N     = 2;
  localparam int EM_LIMIT = 0;
  localparam int EM_STOP  = 1;

  localparam int ADR_FLAGS   = 'h00;
  localparam int ADR_SOFTRST = 'h05;
  localparam int ADR_STATUS  = 'h07;

  typedef struct packed {
    logic       rsvd;
    logic       stop;
    logic       prof;
    logic       limit;
    logic [3:0] cfg;
  } status_t;

  // Indexed flag command: cmd[3] is the value, cmd[2:0] the flag index.
  function automatic logic [FLAG_N-1:0] flag_cmd_apply(
      input logic [FLAG_N-1:0] cur,
      input logic [3:0]        cmd,
      input logic [FLAG_N-1:0] lock);
    logic [FLAG_N-1:0] r;
    r = cur;
    if (!lock[cmd[2:0]]) r[cmd[2:0]] = cmd[3];
    return r;
  endfunction

  function automatic logic [7:0] pack_status(
      input logic [3:0] cfg,
      input logic       limit,
      input logic       prof,
      input logic       stop);
    status_t s;
    s.rsvd  = 1'b0;
    s.stop  = stop;
    s.prof  = prof;
    s.limit = limit;
    s.cfg   = cfg;
    return s;
  endfunction

endpackage

// File: rtl/emflag_sync_latch.sv
module emflag_sync_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clr_req,
  output logic flag,
  output logic pin_low_s
);

  logic [SYNC_STAGES-1:0] sh;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC_STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_low_s = ~sh[SYNC_STAGES-1];

  // Low level sets; the release needs a high level plus a status write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (pin_low_s) flag <= 1'b1;
    else if (clr_req)   flag <= 1'b0;
  end

endmodule

// File: rtl/emflag_bank.sv
module emflag_bank
  import emflag_pkg::*;
#(
  parameter logic [FLAG_N-1:0] LOCK_MASK = 8'b0000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [3:0]        cmd,
  input  logic              prof_start,
  input  logic              prof_done,
  output logic [FLAG_N-1:0] flags
);

  logic [FLAG_N-1:0] nxt;

  always_comb begin
    nxt = flags;
    if (host_wr) nxt = flag_cmd_apply(flags, cmd, LOCK_MASK);
    if (prof_done)       nxt[0] = 1'b0;
    else if (prof_start) nxt[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

endmodule

// File: rtl/emflag_status.sv
module emflag_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       soft_hit,
  input  logic [3:0] cfg_in,
  output logic [3:0] cfg,
  output logic       soft_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      soft_pulse <= 1'b0;
    end else begin
      soft_pulse <= soft_hit;
      if (cfg_wr)        cfg <= cfg_in;
      else if (soft_hit) cfg <= '0;
    end
  end

endmodule

// File: rtl/emerg_flag_regs.sv
module emerg_flag_regs
  import emflag_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              limit_n,
  input  logic              stop_n,
  input  logic              prof_start,
  input  logic              prof_done,
  output logic [7:0]        flags_o,
  output logic              cmd_zero,
  output logic              decel_req,
  output logic              soft_rst_o
);

  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(ADR_FLAGS);
  localparam logic [ADDR_W-1:0] A_SRS = ADDR_W'(ADR_SOFTRST);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(ADR_STATUS);

  // Named decode events, also observed by the checker.
  logic flag_wr, status_wr, soft_hit;
  assign flag_wr   = wr_en && (wr_addr == A_FLG);
  assign status_wr = wr_en && (wr_addr == A_STA);
  assign soft_hit  = wr_en && (wr_addr == A_SRS) && (wr_data == 8'h00);

  logic [EM_N-1:0] pins_n, em_flag, em_low;
  assign pins_n[EM_LIMIT] = limit_n;
  assign pins_n[EM_STOP]  = stop_n;

  generate
    for (genvar g = 0; g < EM_N; g++) begin : g_em
      emflag_sync_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pins_n[g]),
        .clr_req   (status_wr),
        .flag      (em_flag[g]),
        .pin_low_s (em_low[g])
      );
    end
  endgenerate

  logic lim_low_s, stop_low_s;
  assign lim_low_s  = em_low[EM_LIMIT];
  assign stop_low_s = em_low[EM_STOP];

  logic [FLAG_N-1:0] flags;
  emflag_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (flag_wr),
    .cmd        (wr_data[3:0]),
    .prof_start (prof_start),
    .prof_done  (prof_done),
    .flags      (flags)
  );

  logic [3:0] cfg;
  emflag_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (status_wr),
    .soft_hit   (soft_hit),
    .cfg_in     (wr_data[3:0]),
    .cfg        (cfg),
    .soft_pulse (soft_rst_o)
  );

  assign flags_o   = flags;
  assign cmd_zero  = em_flag[EM_LIMIT];
  assign decel_req = em_flag[EM_STOP];

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_FLG)
      rd_data = flags;
    else if (rd_addr == A_STA)
      rd_data = pack_status(cfg, em_flag[EM_LIMIT], flags[0], em_flag[EM_STOP]);
  end

endmodule

// File: rtl/emflag_chk.sv
module emflag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       status_wr,
  input logic       soft_hit,
  input logic       lim_low_s,
  input logic       stop_low_s,
  input logic       prof_done,
  input logic [7:0] flags_o,
  input logic       cmd_zero,
  input logic       decel_req,
  input logic       soft_rst_o
);

  p_locked_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[1] == 1'b0);

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prof_done |=> !flags_o[0]);

  p_limit_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lim_low_s |=> cmd_zero);

  p_stop_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_low_s |=> decel_req);

  p_limit_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_zero) |-> $past(status_wr));

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decel_req && !status_wr) |=> decel_req);

  p_low_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && lim_low_s) |=> cmd_zero);

  p_soft_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_hit |=> soft_rst_o);

  p_soft_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (!soft_rst_o || $past(soft_hit)));

endmodule

bind emerg_flag_regs emflag_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_wr  (status_wr),
  .soft_hit   (soft_hit),
  .lim_low_s  (lim_low_s),
  .stop_low_s (stop_low_s),
  .prof_done  (prof_done),
  .flags_o    (flags_o),
  .cmd_zero   (cmd_zero),
  .decel_req  (decel_req),
  .soft_rst_o (soft_rst_o)
);

// File: tb/emerg_flag_regs_test.sv
`timescale 1ns/100ps
module emerg_flag_regs_test;

  localparam int AW   = 6;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          limit_n = 1'b1, stop_n = 1'b1;
  logic          prof_start = 1'b0, prof_done = 1'b0;
  logic [7:0]    flags_o;
  logic          cmd_zero, decel_req, soft_rst_o;

  always #2.5 clk = ~clk;

  emerg_flag_regs #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .limit_n(limit_n), .stop_n(stop_n), .prof_start(prof_start),
    .prof_done(prof_done), .flags_o(flags_o), .cmd_zero(cmd_zero),
    .decel_req(decel_req), .soft_rst_o(soft_rst_o));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: behavioural, pin history in queues.
  bit [7:0] m_flags;
  bit       m_lim, m_stop, m_soft;
  bit [3:0] m_cfg;
  bit       lq[$], sq[$];

  task automatic model_clear();
    m_flags = 0; m_lim = 0; m_stop = 0; m_soft = 0; m_cfg = 0;
    lq.delete(); sq.delete();
    for (int i = 0; i < SYNC; i++) begin lq.push_back(1'b1); sq.push_back(1'b1); end
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) model_clear();
    else begin
      bit lim_hi, stop_hi, stw;
      lim_hi  = lq[SYNC-1];
      stop_hi = sq[SYNC-1];
      lq.push_front(limit_n); void'(lq.pop_back());
      sq.push_front(stop_n);  void'(sq.pop_back());
      stw = wr_en && wr_addr == 7;
      if (!lim_hi) m_lim = 1; else if (stw) m_lim = 0;
      if (!stop_hi) m_stop = 1; else if (stw) m_stop = 0;
      if (wr_en && wr_addr == 0 && wr_data[2:0] != 3'd1)
        m_flags[wr_data[2:0]] = wr_data[3];
      if (prof_done) m_flags[0] = 0; else if (prof_start) m_flags[0] = 1;
      m_soft = wr_en && wr_addr == 5 && wr_data == 0;
      if (stw) m_cfg = wr_data[3:0]; else if (m_soft) m_cfg = 0;
    end
  end

  function automatic bit [7:0] exp_rd(input bit [AW-1:0] a);
    if (a == 0) return m_flags;
    if (a == 7) return {1'b0, m_stop, m_flags[0], m_lim, m_cfg};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R1 flags_o", flags_o, m_flags);
      chk("R8 cmd_zero", cmd_zero, m_lim);
      chk("R8 decel_req", decel_req, m_stop);
      chk("R9 soft_rst_o", soft_rst_o, m_soft);
      chk("R7 rd_data", rd_data, exp_rd(rd_addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    rd_addr = AW'(a);
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reset flags", flags_o, 0);
    chk("R10 reset cmd_zero", cmd_zero, 0);
    rd_chk("R10 reset status", 7, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 indexed writes
    wr(0, 8'h0B);
    chk("R1 set idx3", flags_o, 8'h08);
    wr(0, 8'hFF);
    chk("R1 set idx7, high bits ignored", flags_o, 8'h88);
    wr(0, 8'h73);
    chk("R1 clear idx3", flags_o, 8'h80);
    // R2 protected index
    wr(0, 8'h09);
    chk("R2 idx1 locked", flags_o, 8'h80);
    rd_chk("R10 unused addr", 12, 0);
    rd_chk("R1 read flags", 0, 8'h80);

    // R3 profile events
    @(negedge clk); prof_start = 1;
    @(negedge clk); prof_start = 0;
    chk("R3 start sets", flags_o[0], 1);
    prof_start = 1; prof_done = 1;
    @(negedge clk); prof_start = 0; prof_done = 0;
    chk("R3 done wins", flags_o[0], 0);
    prof_done = 1; wr(0, 8'h08); prof_done = 0;
    chk("R3 event beats host", flags_o[0], 0);

    // R4/R6/R5 limit path
    limit_n = 0;
    repeat (2) @(negedge clk);
    chk("R4 not yet set", cmd_zero, 0);
    @(negedge clk);
    chk("R4 set after sync", cmd_zero, 1);
    wr(7, 8'hA5);
    chk("R6 held while low", cmd_zero, 1);
    rd_chk("R6 cfg updated", 7, 8'h15);
    limit_n = 1;
    wr(7, 8'h06);
    chk("R5 early write ignored", cmd_zero, 1);
    repeat (4) @(negedge clk);
    chk("R5 high alone keeps", cmd_zero, 1);
    wr(7, 8'h03);
    chk("R5 release", cmd_zero, 0);

    // stop path
    stop_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 decel set", decel_req, 1);
    stop_n = 1;
    repeat (4) @(negedge clk);
    chk("R5 decel held", decel_req, 1);
    wr(7, 8'h09);
    chk("R5 decel release", decel_req, 0);

    // R9 soft reset
    wr(0, 8'h0A);
    wr(5, 8'h01);
    rd_chk("R9 nonzero no effect", 7, 8'h09);
    @(negedge clk); wr_en = 1; wr_addr = 5; wr_data = 0;
    @(negedge clk); wr_en = 0;
    chk("R9 pulse", soft_rst_o, 1);
    chk("R9 flags kept", flags_o, 8'h84);
    rd_chk("R9 cfg cleared", 7, 8'h00);
    @(negedge clk);
    chk("R9 single pulse", soft_rst_o, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_en      = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: wr_addr = 0;
        1: wr_addr = 5;
        2: wr_addr = 7;
        default: wr_addr = AW'($urandom);
      endcase
      wr_data    = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      rd_addr    = (($urandom % 2) == 0) ? AW'(7) : AW'($urandom % 9);
      prof_start = ($urandom % 8) == 0;
      prof_done  = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) limit_n = ~limit_n;
      if (($urandom % 16) == 0) stop_n  = ~stop_n;
    end
    @(negedge clk);
    wr_en = 0; prof_start = 0; prof_done = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule